// File: doc/BRIEF.md
# Converter Reference Source Controller

This block chooses the reference that feeds an on-chip converter. There are four choices: the internal reference buffer at its high level (2.5 V), the same buffer at its low level (1.25 V), the battery rail, or an external reference pin. Software-level select bits are resolved every cycle into one legal source. Conflicting selects are arbitrated. A request for the high buffer level is clipped when the battery status shows a low supply. The block then sequences the analog controls and holds a ready flag low until the new reference can be trusted.

All delays are measured in pulses of a one-microsecond tick input. Each cycle in which the tick is high counts as one microsecond. The battery path closes in two stages with a fixed gap between them. A buffer turn-on or level change waits a settling interval before ready rises. A fast-discharge enable is raised only for downward transitions where discharge is allowed, and only while that settling interval runs.

Top module: `vref_source_ctrl`

## Requirements
- R1: When `req_bat` is 1, the battery is the resolved source whatever `req_buf` says, and `buf_en` is 0 from the next cycle. With `req_bat`=0 and `req_buf`=0, the external pin is the source: every drive output is 0 and `ref_ready` is 1 from the next cycle.
- R2: With `req_buf`=1 and `req_bat`=0, `buf_hi` is 1 only if `req_hi`=1 and `bat_ok`=1. Otherwise the buffer runs at the low level (`buf_hi`=0).
- R3: `lvl_err` is set in the cycle after a clipped high-level request (`req_buf`=1, `req_bat`=0, `req_hi`=1, `bat_ok`=0). It then stays 1 until reset.
- R4: On a change to the battery source, `bat_sw` rises on the next cycle while `bat_sw_dly` and `ref_ready` stay 0. Both `bat_sw_dly` and `ref_ready` rise in the cycle after the BAT_DLY_US-th tick.
- R5: After the buffer is turned on or its level changes, `buf_en` is 1 and `ref_ready` is 0 until the cycle after the SETTLE_US-th tick.
- R6: `dis_en` is raised on a source change only if `fast_dis_req` is 1 in that cycle and the transition is one of: high to low, battery to low, or battery to high with `bat_gt_25`=1. It stays 0 for every other transition.
- R7: `dis_en` is only 1 while the buffer is settling. It falls together with the rise of `ref_ready`.
- R8: A change of the resolved source while a delay is running restarts that delay from zero. A tick in the same cycle as the change is not counted.
- R9: After reset, all drive outputs and `lvl_err` are 0 and `ref_ready` is 1 (the external source is selected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-microsecond time base; each high cycle counts once |
| req_buf | input | 1 | Request the internal buffer |
| req_hi | input | 1 | Request the high buffer level |
| req_bat | input | 1 | Request the battery as reference |
| fast_dis_req | input | 1 | Ask for fast discharge on this transition |
| bat_ok | input | 1 | Battery above the high-level threshold (2.75 V) |
| bat_gt_25 | input | 1 | Battery above 2.5 V |
| buf_en | output | 1 | Internal buffer enable |
| buf_hi | output | 1 | Buffer level: 1 high, 0 low |
| bat_sw | output | 1 | First-stage battery switch |
| bat_sw_dly | output | 1 | Delayed second-stage battery switch |
| dis_en | output | 1 | Fast-discharge enable |
| ref_ready | output | 1 | Reference settled |
| lvl_err | output | 1 | Sticky flag for a clipped level request |

## Verification
A select change and the tick that would complete a running delay can land in the same clock cycle. The bench provokes this by driving a new source together with the final settling tick. It then checks that ready stays low and that a full new interval of ticks is needed, so the restart wins and the tick is dropped. Every pairing of old and new request is also swept across battery status, the 2.5 V status and the discharge request. For each case the bench computes the expected drive pattern, discharge permission and ready timing arithmetically, tick by tick.

// File: rtl/vref_ctrl_pkg.sv
package vref_ctrl_pkg;

    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_LO  = 2'd1,
        SRC_HI  = 2'd2,
        SRC_BAT = 2'd3
    } vref_src_e;

    typedef enum logic [2:0] {
        PH_EXT      = 3'd0,
        PH_SETTLE   = 3'd1,
        PH_INT_RDY  = 3'd2,
        PH_BAT_WAIT = 3'd3,
        PH_BAT_RDY  = 3'd4
    } vref_phase_e;

    typedef struct packed {
        logic buf_sel;
        logic hi_sel;
        logic bat_sel;
    } vref_req_t;

    typedef struct packed {
        logic buf_en;
        logic buf_hi;
        logic bat_sw;
        logic bat_sw_dly;
        logic ready;
    } vref_drive_t;

    // battery request dominates; buffer level gated by battery status
    function automatic vref_src_e resolve_src(vref_req_t r, logic bat_ok);
        if (r.bat_sel)
            return SRC_BAT;
        else if (r.buf_sel)
            return (r.hi_sel && bat_ok) ? SRC_HI : SRC_LO;
        else
            return SRC_EXT;
    endfunction

    function automatic logic is_internal(vref_src_e s);
        return (s == SRC_LO) || (s == SRC_HI);
    endfunction

    // downward transitions where a fast discharge is permitted
    function automatic logic discharge_allowed(vref_src_e from_s, vref_src_e to_s,
                                               logic bat_gt_25);
        logic ok;
        ok = 1'b0;
        if (from_s == SRC_HI  && to_s == SRC_LO) ok = 1'b1;
        if (from_s == SRC_BAT && to_s == SRC_LO) ok = 1'b1;
        if (from_s == SRC_BAT && to_s == SRC_HI && bat_gt_25) ok = 1'b1;
        return ok;
    endfunction

endpackage

// File: rtl/vref_arbiter.sv
module vref_arbiter
    import vref_ctrl_pkg::*;
(
    input  vref_req_t req,
    input  logic      bat_ok,
    output vref_src_e target,
    output logic      level_clip
);
    always_comb begin
        target     = resolve_src(req, bat_ok);
        level_clip = req.buf_sel && !req.bat_sel && req.hi_sel && !bat_ok;
    end
endmodule

// File: rtl/vref_tick_timer.sv
module vref_tick_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        done = !clear && run && tick && (cnt == limit - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= done ? '0 : cnt + CNT_W'(1);
        end
    end

    // R8: the count never runs past the programmed limit
    a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit));
endmodule

// File: rtl/vref_seq.sv
module vref_seq
    import vref_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vref_src_e   target,
    input  logic        level_clip,
    input  logic        fast_dis_req,
    input  logic        bat_gt_25,
    input  logic        delay_done,
    output logic        change,
    output vref_phase_e phase,
    output vref_src_e   cur_src,
    output vref_drive_t drive,
    output logic        dis_en,
    output logic        lvl_err
);
    always_comb begin
        change           = (target != cur_src);
        drive.buf_en     = (phase == PH_SETTLE) || (phase == PH_INT_RDY);
        drive.buf_hi     = drive.buf_en && (cur_src == SRC_HI);
        drive.bat_sw     = (phase == PH_BAT_WAIT) || (phase == PH_BAT_RDY);
        drive.bat_sw_dly = (phase == PH_BAT_RDY);
        drive.ready      = (phase == PH_EXT) || (phase == PH_INT_RDY) ||
                           (phase == PH_BAT_RDY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_EXT;
            cur_src <= SRC_EXT;
            dis_en  <= 1'b0;
            lvl_err <= 1'b0;
        end else begin
            if (level_clip) lvl_err <= 1'b1;
            if (change) begin
                cur_src <= target;
                dis_en  <= is_internal(target) && fast_dis_req &&
                           discharge_allowed(cur_src, target, bat_gt_25);
                case (target)
                    SRC_EXT: phase <= PH_EXT;
                    SRC_BAT: phase <= PH_BAT_WAIT;
                    default: phase <= PH_SETTLE;
                endcase
            end else if (delay_done) begin
                phase  <= (phase == PH_BAT_WAIT) ? PH_BAT_RDY : PH_INT_RDY;
                dis_en <= 1'b0;
            end
        end
    end

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(lvl_err) |-> lvl_err);
    a_r7_dis_only_settling: assert property (@(posedge clk) disable iff (rst)
        dis_en |-> (drive.buf_en && !drive.ready));
    a_r8_change_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (change && target != SRC_EXT) |=> !drive.ready);
    a_r4_dly_after_first: assert property (@(posedge clk) disable iff (rst)
        $rose(drive.bat_sw_dly) |-> $past(drive.bat_sw));
endmodule

// File: rtl/vref_source_ctrl.sv
module vref_source_ctrl
    import vref_ctrl_pkg::*;
#(
    parameter int BAT_DLY_US = 700,
    parameter int SETTLE_US  = 3500
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic req_buf,
    input  logic req_hi,
    input  logic req_bat,
    input  logic fast_dis_req,
    input  logic bat_ok,
    input  logic bat_gt_25,
    output logic buf_en,
    output logic buf_hi,
    output logic bat_sw,
    output logic bat_sw_dly,
    output logic dis_en,
    output logic ref_ready,
    output logic lvl_err
);
    localparam int MAX_US = (BAT_DLY_US > SETTLE_US) ? BAT_DLY_US : SETTLE_US;
    localparam int CNT_W  = $clog2(MAX_US + 1);
    localparam logic [CNT_W-1:0] LIM_BAT    = CNT_W'(BAT_DLY_US);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_US);

    vref_req_t   req;
    vref_src_e   target;
    vref_src_e   cur_src;
    vref_phase_e phase;
    vref_drive_t drive;
    logic        level_clip;
    logic        change;
    logic        delay_done;
    logic        timer_run;
    logic [CNT_W-1:0] timer_lim;

    always_comb begin
        req.buf_sel = req_buf;
        req.hi_sel  = req_hi;
        req.bat_sel = req_bat;
        timer_run   = (phase == PH_SETTLE) || (phase == PH_BAT_WAIT);
        timer_lim   = (phase == PH_BAT_WAIT) ? LIM_BAT : LIM_SETTLE;
    end

    vref_arbiter u_arb (
        .req        (req),
        .bat_ok     (bat_ok),
        .target     (target),
        .level_clip (level_clip)
    );

    vref_tick_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (change),
        .run   (timer_run),
        .tick  (us_tick),
        .limit (timer_lim),
        .done  (delay_done)
    );

    vref_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .target       (target),
        .level_clip   (level_clip),
        .fast_dis_req (fast_dis_req),
        .bat_gt_25    (bat_gt_25),
        .delay_done   (delay_done),
        .change       (change),
        .phase        (phase),
        .cur_src      (cur_src),
        .drive        (drive),
        .dis_en       (dis_en),
        .lvl_err      (lvl_err)
    );

    always_comb begin
        buf_en     = drive.buf_en;
        buf_hi     = drive.buf_hi;
        bat_sw     = drive.bat_sw;
        bat_sw_dly = drive.bat_sw_dly;
        ref_ready  = drive.ready;
    end

    a_r1_bat_wins: assert property (@(posedge clk) disable iff (rst)
        req_bat |=> (bat_sw && !buf_en));
    a_r2_hi_needs_bat_ok: assert property (@(posedge clk) disable iff (rst)
        (buf_hi && !$past(buf_hi)) |-> $past(bat_ok));
    a_r5_not_ready_on_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_en) |-> !ref_ready);
    a_r1_exclusive_paths: assert property (@(posedge clk) disable iff (rst)
        !(buf_en && bat_sw));
endmodule

// File: tb/tb_vref_source_ctrl.sv
module tb_vref_source_ctrl;
    localparam int BAT_N = 5;
    localparam int SET_N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0, req_buf = 1'b0, req_hi = 1'b0, req_bat = 1'b0;
    logic fast_dis_req = 1'b0, bat_ok = 1'b1, bat_gt_25 = 1'b1;
    logic buf_en, buf_hi, bat_sw, bat_sw_dly, dis_en, ref_ready, lvl_err;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    vref_source_ctrl #(.BAT_DLY_US(BAT_N), .SETTLE_US(SET_N)) dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .req_buf(req_buf),
        .req_hi(req_hi), .req_bat(req_bat), .fast_dis_req(fast_dis_req),
        .bat_ok(bat_ok), .bat_gt_25(bat_gt_25), .buf_en(buf_en),
        .buf_hi(buf_hi), .bat_sw(bat_sw), .bat_sw_dly(bat_sw_dly),
        .dis_en(dis_en), .ref_ready(ref_ready), .lvl_err(lvl_err)
    );

    // source codes used by the bench: 0 ext, 1 low, 2 high, 3 battery
    function automatic logic [5:0] outs();
        return {buf_en, buf_hi, bat_sw, bat_sw_dly, dis_en, ref_ready};
    endfunction

    function automatic logic [5:0] expect_of(int src, logic settled, logic dis);
        case (src)
            0: return 6'b000001;
            1: return {1'b1, 1'b0, 2'b00, dis, settled};
            2: return {1'b1, 1'b1, 2'b00, dis, settled};
            default: return {2'b00, 1'b1, settled, 1'b0, settled};
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_once();
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
    endtask

    // request codes: 0 none, 1 low, 2 high, 3 battery, 4 battery+buffer
    task automatic drive_req(int r);
        req_buf = (r == 1) || (r == 2) || (r == 4);
        req_hi  = (r == 2);
        req_bat = (r == 3) || (r == 4);
    endtask

    function automatic int resolve(int r, logic ok);
        if (r >= 3) return 3;
        if (r == 2) return ok ? 2 : 1;
        return r;
    endfunction

    function automatic logic allowed(int f, int t, logic b25);
        return (f == 2 && t == 1) || (f == 3 && t == 1) || (f == 3 && t == 2 && b25);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R8 act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic err_exp;
        int cur;
        err_exp = 1'b0;
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        step();
        // R9 reset state
        check("R9 reset outputs", {26'd0, outs()}, 32'b000001);
        check("R9 reset err", {31'd0, lvl_err}, 0);
        cur = 0;

        // exhaustive sweep of old/new requests and status inputs
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 5; n++) begin
                for (int k = 0; k < 8; k++) begin
                    int tgt, lim;
                    logic de;
                    string tag;
                    bat_ok = 1'b1; bat_gt_25 = 1'b1; fast_dis_req = 1'b0;
                    drive_req(o);
                    step();
                    for (int t = 0; t < SET_N; t++) tick_once();
                    cur = o;
                    bat_ok = k[0]; bat_gt_25 = k[1]; fast_dis_req = k[2];
                    drive_req(n);
                    if (n == 2 && !k[0]) err_exp = 1'b1;
                    tgt = resolve(n, k[0]);
                    step();
                    check("R3 sticky error", {31'd0, lvl_err}, {31'd0, err_exp});
                    if (tgt == cur) begin
                        check("R8 no change", {26'd0, outs()}, {26'd0, expect_of(cur, 1'b1, 1'b0)});
                        continue;
                    end
                    de = (tgt == 1 || tgt == 2) && k[2] && allowed(cur, tgt, k[1]);
                    lim = (tgt == 3) ? BAT_N : ((tgt == 0) ? 0 : SET_N);
                    tag = (tgt == 0) ? "R1 external" : (tgt == 3) ? "R4 battery" :
                          (n == 2 && !k[0]) ? "R2 level clip" : "R5 settle";
                    check(tag, {26'd0, outs()}, {26'd0, expect_of(tgt, lim == 0, de)});
                    check("R6 discharge", {31'd0, dis_en}, {31'd0, de});
                    for (int t = 1; t <= lim; t++) begin
                        tick_once();
                        check((t == lim) ? "R7 ready" : "R5 wait", {26'd0, outs()},
                              {26'd0, expect_of(tgt, t == lim, de && (t < lim))});
                    end
                end
            end
        end

        // R8 restart: low -> (3 ticks) -> high restarts settling
        bat_ok = 1'b1; fast_dis_req = 1'b0;
        drive_req(0); step();
        drive_req(1); step();
        repeat (3) tick_once();
        drive_req(2); step();
        for (int t = 1; t < SET_N; t++) tick_once();
        check("R8 restart not ready", {31'd0, ref_ready}, 0);
        tick_once();
        check("R8 restart ready", {31'd0, ref_ready}, 1);

        // R8 same-cycle: final tick coincides with a level change
        drive_req(1); step();
        for (int t = 1; t < SET_N; t++) tick_once();
        drive_req(2);
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        check("R8 tick with change", {26'd0, outs()}, {26'd0, expect_of(2, 1'b0, 1'b0)});
        for (int t = 1; t < SET_N; t++) tick_once();
        check("R8 tick dropped", {31'd0, ref_ready}, 0);
        tick_once();
        check("R8 full interval", {31'd0, ref_ready}, 1);

        // R1 both requested: battery wins
        drive_req(4); step();
        check("R1 both selects", {26'd0, outs()}, {26'd0, expect_of(3, 1'b0, 1'b0)});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule